// File: doc/BRIEF.md
# Conditional Skip Decision Unit

This block decides whether a skip-class instruction of a 16-bit accumulator machine skips the next word. It recognises a skip word by the top six bits of the instruction. It then tests selected conditions on the accumulator, the carry bit, a memory parity error flag and a set of sense switches, and delivers one registered decision. The program-counter logic uses that decision to advance by one extra word.

The low bits of the word form a mask of independent tests. When the reverse flag is clear, the word skips only if every selected test is true. When the flag is set, the decision is inverted, so the word skips if at least one selected test is false. Because each mask bit is its own test, a programmer can merge several tests into one word the way micro-orders are merged. The zero test is separate from the sign test, so no single word can skip on strictly positive values. The decision is captured on a valid strobe, and it holds between strobes.

Top module: `skip_decision_unit`

## Requirements
- R1: On a clock edge with `valid_i` high, `is_skip_o` becomes 1 if `instr_i[15:10]` equals binary 100000 and 0 otherwise. Bits are numbered 1 (most significant, `instr_i[15]`) to 16 (`instr_i[0]`).
- R2: Whenever `is_skip_o` is 0, `skip_taken_o` is also 0.
- R3: The test mask maps as follows: `instr_i[8]` selects accumulator positive, `instr_i[7]` selects parity error present, `instr_i[6]` selects accumulator even, `instr_i[5]` selects accumulator zero, `instr_i[4]` down to `instr_i[1]` select sense switch 1 to 4 reset, and `instr_i[0]` selects carry zero. `instr_i[9]` is the reverse flag.
- R4: With the reverse flag clear, a skip word skips exactly when every selected test holds. If no test is selected (octal 100000), it always skips.
- R5: With the reverse flag set, a skip word skips exactly when at least one selected test fails. If no test is selected (octal 101000), it never skips.
- R6: "Positive" means `acc_i[15]` is 0, so zero counts as positive. "Even" means `acc_i[0]` is 0.
- R7: The zero test only checks that all accumulator bits are 0. A word that selects zero never skips on a nonzero accumulator, whatever the other tests select.
- R8: The outputs change only on a clock edge with `valid_i` high, and they take the values for the inputs sampled at that edge. With `valid_i` low, they hold their values.
- R9: While `rst_n` is low, both outputs are 0.
- R10: `sense_sw_i[k-1]` is 1 when sense switch k is set. The "switch k reset" test holds when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | Instruction strobe; the decision is captured when this is high |
| instr_i | input | 16 | Instruction word |
| acc_i | input | 16 | Accumulator value |
| carry_i | input | 1 | Carry bit |
| parity_err_i | input | 1 | Memory parity error flag |
| sense_sw_i | input | 4 | Sense switch states, 1 = set |
| is_skip_o | output | 1 | Registered decode flag: the last captured word was a skip |
| skip_taken_o | output | 1 | Registered skip decision |

## Verification
The assertions assume that `valid_i`, `instr_i` and the condition inputs are steady around the sampling edge. They also assume that `valid_i` stays low while reset is active. The bench meets both assumptions by changing every input on the falling clock edge only and by holding the strobe low until reset is released. The properties that look at the previous cycle's inputs treat `instr_i` as meaningful only in cycles where `valid_i` was high. The bench therefore keeps the word and the strobe together, and it drops the strobe when it tests that the outputs hold.

// File: rtl/skip_unit_pkg.sv
package skip_unit_pkg;
   // major opcode field that marks a skip word
   localparam int unsigned OPC_W    = 6;
   localparam logic [OPC_W-1:0] SKIP_OPC = 6'b100000;
   // tests that do not come from the switch bank: sign, parity, parity-of-value, zero, carry
   localparam int unsigned FIXED_TESTS = 5;

   function automatic int unsigned test_count(input int unsigned sw_n);
      return FIXED_TESTS + sw_n;
   endfunction
endpackage

// File: rtl/skip_decode.sv
module skip_decode
   import skip_unit_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned SW_N   = 4,
   localparam int unsigned TEST_N = test_count(SW_N)
) (
   input  logic [WORD_W-1:0] word_i,
   output logic              is_skip_o,
   output logic              reverse_o,
   output logic [TEST_N-1:0] mask_o
);
   initial begin
      assert (WORD_W == OPC_W + 1 + TEST_N)
         else $fatal(1, "skip_decode: word width does not fit opcode, reverse and mask");
   end

   assign is_skip_o = (word_i[WORD_W-1 -: OPC_W] == SKIP_OPC);
   assign reverse_o = word_i[TEST_N];
   assign mask_o    = word_i[TEST_N-1:0];
endmodule

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
   import skip_unit_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned SW_N   = 4,
   localparam int unsigned TEST_N = test_count(SW_N)
) (
   input  logic [WORD_W-1:0] acc_i,
   input  logic              carry_i,
   input  logic              parity_err_i,
   input  logic [SW_N-1:0]   sense_sw_i,
   output logic [TEST_N-1:0] cond_o
);
   initial begin
      assert (SW_N >= 1) else $fatal(1, "skip_cond_eval: at least one switch required");
      assert (WORD_W >= 2) else $fatal(1, "skip_cond_eval: accumulator too narrow");
   end

   // slot layout, most significant first: sign, parity, even, zero, switches, carry
   assign cond_o[TEST_N-1] = ~acc_i[WORD_W-1];
   assign cond_o[TEST_N-2] = parity_err_i;
   assign cond_o[TEST_N-3] = ~acc_i[0];
   assign cond_o[TEST_N-4] = ~|acc_i;
   assign cond_o[0]        = ~carry_i;

   for (genvar g = 0; g < SW_N; g++) begin : g_switch
      // switch g+1 sits in slot SW_N-g; a reset switch satisfies the test
      assign cond_o[SW_N-g] = ~sense_sw_i[g];
   end
endmodule

// File: rtl/skip_combine.sv
module skip_combine #(
   parameter int unsigned TEST_N = 9
) (
   input  logic              is_skip_i,
   input  logic              reverse_i,
   input  logic [TEST_N-1:0] mask_i,
   input  logic [TEST_N-1:0] cond_i,
   output logic              take_o
);
   logic [TEST_N-1:0] satisfied;
   logic              all_ok;

   initial begin
      assert (TEST_N >= 1) else $fatal(1, "skip_combine: empty mask");
   end

   // an unselected test is treated as satisfied
   assign satisfied = cond_i | ~mask_i;
   assign all_ok    = &satisfied;
   assign take_o    = is_skip_i & (all_ok ^ reverse_i);
endmodule

// File: rtl/skip_decision_unit.sv
module skip_decision_unit
   import skip_unit_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned SW_N   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [WORD_W-1:0] instr_i,
   input  logic [WORD_W-1:0] acc_i,
   input  logic              carry_i,
   input  logic              parity_err_i,
   input  logic [SW_N-1:0]   sense_sw_i,
   output logic              is_skip_o,
   output logic              skip_taken_o
);
   localparam int unsigned TEST_N = test_count(SW_N);
   localparam int unsigned ZERO_SLOT = TEST_N - 4;

   logic              dec_skip;
   logic              dec_rev;
   logic [TEST_N-1:0] dec_mask;
   logic [TEST_N-1:0] conds;
   logic              take_c;

   skip_decode #(.WORD_W(WORD_W), .SW_N(SW_N)) u_decode (
      .word_i    (instr_i),
      .is_skip_o (dec_skip),
      .reverse_o (dec_rev),
      .mask_o    (dec_mask)
   );

   skip_cond_eval #(.WORD_W(WORD_W), .SW_N(SW_N)) u_cond (
      .acc_i        (acc_i),
      .carry_i      (carry_i),
      .parity_err_i (parity_err_i),
      .sense_sw_i   (sense_sw_i),
      .cond_o       (conds)
   );

   skip_combine #(.TEST_N(TEST_N)) u_combine (
      .is_skip_i (dec_skip),
      .reverse_i (dec_rev),
      .mask_i    (dec_mask),
      .cond_i    (conds),
      .take_o    (take_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_skip_o    <= 1'b0;
         skip_taken_o <= 1'b0;
      end else if (valid_i) begin
         is_skip_o    <= dec_skip;
         skip_taken_o <= take_c;
      end
   end

   // R2: no skip decision without a skip word
   assert_nonskip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !is_skip_o |-> !skip_taken_o);

   // R1: decode flag follows the opcode field of the strobed word
   assert_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> (is_skip_o == $past(instr_i[WORD_W-1 -: OPC_W] == SKIP_OPC)));

   // R8: outputs hold without a strobe
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(is_skip_o) && $stable(skip_taken_o)));

   // R4: empty mask, forward sense, always skips
   assert_empty_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && instr_i[WORD_W-1 -: OPC_W] == SKIP_OPC && !instr_i[TEST_N]
       && instr_i[TEST_N-1:0] == '0) |=> skip_taken_o);

   // R5: empty mask, reversed sense, never skips
   assert_empty_rev_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && instr_i[WORD_W-1 -: OPC_W] == SKIP_OPC && instr_i[TEST_N]
       && instr_i[TEST_N-1:0] == '0) |=> !skip_taken_o);

   // R7: zero selected in forward sense blocks the skip on any nonzero value
   assert_zero_indep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && instr_i[WORD_W-1 -: OPC_W] == SKIP_OPC && !instr_i[TEST_N]
       && instr_i[ZERO_SLOT] && acc_i != '0) |=> !skip_taken_o);
endmodule

// File: tb/tb_skip_decision_unit.sv
`timescale 1ns/1ps
module tb_skip_decision_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [15:0] instr_i = '0;
   logic [15:0] acc_i = '0;
   logic        carry_i = 1'b0;
   logic        parity_err_i = 1'b0;
   logic [3:0]  sense_sw_i = '0;
   logic        is_skip_o;
   logic        skip_taken_o;

   int applied = 0;
   int miscompares = 0;

   always #4 clk = ~clk;   // 125 MHz

   skip_decision_unit dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
      .acc_i(acc_i), .carry_i(carry_i), .parity_err_i(parity_err_i),
      .sense_sw_i(sense_sw_i), .is_skip_o(is_skip_o), .skip_taken_o(skip_taken_o)
   );

   localparam int NCODES = 16;
   localparam logic [15:0] CODES [NCODES] = '{
      16'o100000, 16'o101000, 16'o100001, 16'o101001,
      16'o100500, 16'o101500, 16'o100041, 16'o101041,
      16'o100030, 16'o101030, 16'o100036, 16'o101036,
      16'o100400, 16'o100040, 16'o100200, 16'o100440
   };

   // reference: expected decision written from the requirement text
   function automatic logic ref_skip(input logic [15:0] w, input logic [15:0] a,
                                     input logic c, input logic p, input logic [3:0] s);
      logic ok;
      if (w[15:10] != 6'b100000) return 1'b0;          // R1, R2
      ok = 1'b1;                                        // R3 map
      if (w[8] && a[15])       ok = 1'b0;               // R6 positive
      if (w[7] && !p)          ok = 1'b0;
      if (w[6] && a[0])        ok = 1'b0;               // R6 even
      if (w[5] && (a != 16'h0)) ok = 1'b0;              // R7
      if (w[4] && s[0])        ok = 1'b0;               // R10 switch 1
      if (w[3] && s[1])        ok = 1'b0;
      if (w[2] && s[2])        ok = 1'b0;
      if (w[1] && s[3])        ok = 1'b0;
      if (w[0] && c)           ok = 1'b0;
      return w[9] ? !ok : ok;                           // R4, R5
   endfunction

   task automatic check(input logic exp_dec, input logic exp_take, input string tag);
      applied++;
      if (is_skip_o !== exp_dec || skip_taken_o !== exp_take) begin
         miscompares++;
         $display("FAIL %s: instr=%o acc=%h c=%b p=%b sw=%b got dec=%b take=%b expected dec=%b take=%b",
                  tag, instr_i, acc_i, carry_i, parity_err_i, sense_sw_i,
                  is_skip_o, skip_taken_o, exp_dec, exp_take);
      end
   endtask

   // drive at falling edge, capture at rising edge, sample at next falling edge
   task automatic apply(input logic [15:0] w, input logic [15:0] a, input logic c,
                        input logic p, input logic [3:0] s, input string tag);
      @(negedge clk);
      instr_i = w; acc_i = a; carry_i = c; parity_err_i = p; sense_sw_i = s; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      check(w[15:10] == 6'b100000, ref_skip(w, a, c, p, s), tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end

   initial begin
      logic exp_take;
      repeat (3) @(negedge clk);
      check(1'b0, 1'b0, "R9 reset state");
      rst_n = 1'b1;

      // table walk: every code against corner and random operands
      for (int i = 0; i < NCODES; i++) begin
         for (int j = 0; j < 20; j++) begin
            logic [15:0] a;
            logic [31:0] r;
            r = $urandom;
            case (j)
               0: a = 16'h0000;
               1: a = 16'h8000;
               2: a = 16'h0001;
               3: a = 16'h7ffe;
               default: a = r[15:0];
            endcase
            apply(CODES[i], a, r[16], r[17], r[21:18], "R3 R4 R5 R6 R10 table");
         end
      end

      // directed corners
      apply(16'o100000, 16'h8001, 1'b1, 1'b0, 4'hf, "R4 empty mask skips");
      apply(16'o101000, 16'h0000, 1'b0, 1'b1, 4'h0, "R5 empty reversed never");
      apply(16'o100040, 16'h8000, 1'b0, 1'b0, 4'h0, "R7 zero test on sign-only value");
      apply(16'o100440, 16'h0000, 1'b0, 1'b0, 4'h0, "R6 zero counts as positive");
      apply(16'o100020, 16'h0000, 1'b0, 1'b0, 4'b0001, "R10 switch 1 set blocks");
      apply(16'o100002, 16'h0000, 1'b0, 1'b0, 4'b0111, "R10 switch 4 reset skips");
      apply(16'o100200, 16'h0000, 1'b0, 1'b1, 4'h0, "R3 parity error selected");
      apply(16'o140000, 16'h0000, 1'b0, 1'b0, 4'h0, "R1 R2 non-skip word");
      apply(16'o000000, 16'h0000, 1'b0, 1'b0, 4'h0, "R1 R2 all-zero word");
      apply(16'o102000, 16'h0000, 1'b0, 1'b0, 4'h0, "R1 neighbour opcode");

      // R8: load a skipping word, then change inputs without a strobe
      apply(16'o100000, 16'h1234, 1'b0, 1'b0, 4'h0, "R8 preload");
      @(negedge clk);
      instr_i = 16'o101000; acc_i = 16'hffff;
      repeat (3) @(negedge clk);
      check(1'b1, 1'b1, "R8 hold without strobe");
      instr_i = 16'o140000;
      @(negedge clk);
      check(1'b1, 1'b1, "R8 hold with non-skip word present");

      // R8: result is registered, not visible before the edge
      @(negedge clk);
      instr_i = 16'o101000; acc_i = 16'h0; valid_i = 1'b1;
      #1;
      check(1'b1, 1'b1, "R8 no change before edge");
      @(negedge clk);
      valid_i = 1'b0;
      exp_take = ref_skip(16'o101000, 16'h0, carry_i, parity_err_i, sense_sw_i);
      check(1'b1, exp_take, "R8 change after edge");

      // R9: reset mid-run clears outputs
      apply(16'o100000, 16'h0, 1'b0, 1'b0, 4'h0, "R9 preload");
      rst_n = 1'b0;
      #1;
      check(1'b0, 1'b0, "R9 reset clears");
      @(negedge clk);
      rst_n = 1'b1;

      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
   end
endmodule